// File: doc/BRIEF.md
# Two-wire half-duplex command responder

The responder is the target end of a two-wire serial link. The host supplies the serial clock and a data line. It shifts 16-bit command words into the block. Each word appears on a parallel output for one local clock cycle with a valid strobe. A length field in the first word of a command says how many more words belong to that command. When the final word has arrived, the responder takes over the data line and holds it high to show that the command is being worked on.

Local logic decodes the command and prepares the reply. It signals through a one-cycle start strobe that also gives the reply length. The responder then drives the line low for a fixed number of local clock cycles so that the host knows the reply is ready. After that it shifts the reply words out on the host clock. It asks the local logic for each word through a take strobe. After the last reply bit it releases the line and waits for the next command.

Both host signals are brought into the local clock domain through two-stage synchronizers. Host clock edges are detected from the synchronized samples.

Top module: `cmd_responder`

## Requirements
- R1: A command word is 16 bits, most significant bit first. Each bit is sampled on a falling edge of the synchronized host clock. After the 16th falling edge, `cmd_word_o` carries the word and `cmd_valid_o` is high for exactly one local cycle.
- R2: Bits [3:0] of the first word of a command give the number of words that follow it; 0 means a one-word command. `cmd_last_o` is high together with `cmd_valid_o` on the final word of the command and low on all earlier words.
- R3: From the cycle after the final command word until a response starts, the responder drives the line (`sdata_oe_o`=1) at value 1.
- R4: A `rsp_start_i` strobe while busy loads `rsp_word_i` and pulses `rsp_take_o`. The responder then drives the line at 0 for exactly `PULSE_CYC` local cycles.
- R5: After the low pulse, the most significant bit of the response word is on the line. Each falling host clock edge moves to the next bit, so the host samples on rising edges. `rsp_len_i`+1 words are sent. For each word after the first, `rsp_word_i` is loaded at the falling edge that ends the previous word, with a `rsp_take_o` pulse.
- R6: At the falling edge after the last response bit, the responder releases the line (`sdata_oe_o`=0) and accepts a new command.
- R7: Host clock edges while busy or during the low pulse have no effect: no `cmd_valid_o`, and the line keeps its value.
- R8: `rsp_start_i` while receiving a command is ignored: the line stays released.
- R9: After reset the line is released and `cmd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock |
| sdata_i | input | 1 | Host data into the responder |
| sdata_o | output | 1 | Responder data onto the line |
| sdata_oe_o | output | 1 | Responder drives the line when 1 |
| cmd_word_o | output | 16 | Received command word |
| cmd_valid_o | output | 1 | One-cycle strobe for `cmd_word_o` |
| cmd_last_o | output | 1 | Marks the final word of a command |
| rsp_start_i | input | 1 | Local logic has a response ready |
| rsp_len_i | input | 4 | Response word count minus one, sampled with `rsp_start_i` |
| rsp_word_i | input | 16 | Response word to load next |
| rsp_take_o | output | 1 | One-cycle strobe: `rsp_word_i` was loaded |

## Verification
Commands of one, two and three words are sent, with reply lengths of one to three words. This tells apart a length taken from the first word from a fixed count, and shows whether the take strobe advances between words. The first reply word always starts with a 1, so the low pulse can be timed exactly against `PULSE_CYC`. Host clock toggles are sent during the busy phase and a stray start strobe while idle, which separate real ignoring from silently absorbed state. Back-to-back commands show that the line is released and reception restarts cleanly.

// File: rtl/crsp_pkg.sv
package crsp_pkg;
  typedef enum logic [1:0] {
    ST_RX   = 2'd0,
    ST_BUSY = 2'd1,
    ST_RDY  = 2'd2,
    ST_TX   = 2'd3
  } crsp_st_e;
endpackage

// File: rtl/crsp_sync.sv
module crsp_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/crsp_timer.sv
module crsp_timer #(
  parameter int CYC = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(CYC - 1));
endmodule

// File: rtl/cmd_responder.sv
module cmd_responder
  import crsp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LEN_LSB   = 0,
  parameter int LEN_W     = 4,
  parameter int RLEN_W    = 4,
  parameter int PULSE_CYC = 1500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_valid_o,
  output logic              cmd_last_o,
  input  logic              rsp_start_i,
  input  logic [RLEN_W-1:0] rsp_len_i,
  input  logic [WORD_W-1:0] rsp_word_i,
  output logic              rsp_take_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  crsp_st_e          st_q;
  logic [1:0]        sy;
  logic              sclk_s, sd_s, sclk_d, fall;
  logic [WORD_W-1:0] rx_sh, tx_sh, rx_nxt;
  logic [BIT_W-1:0]  bit_q;
  logic [LEN_W-1:0]  cmd_left_q, left_n;
  logic              first_q;
  logic [RLEN_W-1:0] rsp_left_q;
  logic              tmr_done;

  crsp_sync #(.N(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdata_i}),
    .q_o   (sy)
  );
  assign sclk_s = sy[1];
  assign sd_s   = sy[0];
  assign fall   = sclk_d & ~sclk_s;

  crsp_timer #(.CYC(PULSE_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st_q == ST_RDY),
    .done_o(tmr_done)
  );

  assign rx_nxt = {rx_sh[WORD_W-2:0], sd_s};
  assign left_n = first_q ? rx_nxt[LEN_LSB +: LEN_W] : cmd_left_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_RX;
      sclk_d      <= 1'b0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      bit_q       <= '0;
      cmd_left_q  <= '0;
      first_q     <= 1'b1;
      rsp_left_q  <= '0;
      cmd_word_o  <= '0;
      cmd_valid_o <= 1'b0;
      cmd_last_o  <= 1'b0;
      rsp_take_o  <= 1'b0;
    end else begin
      sclk_d      <= sclk_s;
      cmd_valid_o <= 1'b0;
      cmd_last_o  <= 1'b0;
      rsp_take_o  <= 1'b0;
      unique case (st_q)
        ST_RX: if (fall) begin
          rx_sh <= rx_nxt;
          if (bit_q == LAST_BIT) begin
            bit_q       <= '0;
            cmd_word_o  <= rx_nxt;
            cmd_valid_o <= 1'b1;
            cmd_last_o  <= (left_n == '0);
            cmd_left_q  <= left_n;
            first_q     <= (left_n == '0);
            if (left_n == '0) st_q <= ST_BUSY;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_BUSY: if (rsp_start_i) begin
          tx_sh      <= rsp_word_i;
          rsp_left_q <= rsp_len_i;
          rsp_take_o <= 1'b1;
          bit_q      <= '0;
          st_q       <= ST_RDY;
        end
        ST_RDY: if (tmr_done) st_q <= ST_TX;
        ST_TX: if (fall) begin
          if (bit_q == LAST_BIT) begin
            bit_q <= '0;
            if (rsp_left_q == '0) begin
              st_q <= ST_RX;
            end else begin
              rsp_left_q <= rsp_left_q - 1'b1;
              tx_sh      <= rsp_word_i;
              rsp_take_o <= 1'b1;
            end
          end else begin
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
        default: st_q <= ST_RX;
      endcase
    end
  end

  assign sdata_oe_o = (st_q != ST_RX);
  always_comb begin
    unique case (st_q)
      ST_BUSY: sdata_o = 1'b1;
      ST_TX:   sdata_o = tx_sh[WORD_W-1];
      default: sdata_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/crsp_checker.sv
module crsp_checker
  import crsp_pkg::*;
#(
  parameter int PULSE_CYC = 1500
) (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     sdata_o,
  input logic     sdata_oe_o,
  input logic     cmd_valid_o,
  input logic     cmd_last_o,
  input logic     rsp_start_i,
  input crsp_st_e st_q
);
  localparam int RW = $clog2(PULSE_CYC + 2);
  logic [RW-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_run <= '0;
    else if (st_q == ST_RDY)  low_run <= (low_run == RW'(PULSE_CYC + 1)) ? low_run : low_run + 1'b1;
    else                      low_run <= '0;
  end

  assert_strobe_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_last_needs_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_last_o |-> cmd_valid_o);

  assert_busy_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_last_o) |=> (sdata_oe_o && sdata_o));

  assert_ready_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && rsp_start_i) |=> (sdata_oe_o && !sdata_o));

  assert_pulse_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run <= RW'(PULSE_CYC));

  assert_release_after_tx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdata_oe_o) |-> $past(st_q == ST_TX));

  assert_rx_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(st_q == ST_RX));
endmodule

bind cmd_responder crsp_checker #(.PULSE_CYC(PULSE_CYC)) u_crsp_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_last_o (cmd_last_o),
  .rsp_start_i(rsp_start_i),
  .st_q       (st_q)
);

// File: tb/cmd_responder_bench.sv
`timescale 1ns/1ps
module cmd_responder_bench;
  localparam int PULSE = 50;
  localparam int H     = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        sclk_i = 1'b0, sdata_i = 1'b0;
  logic        sdata_o, sdata_oe_o, cmd_valid_o, cmd_last_o, rsp_take_o;
  logic [15:0] cmd_word_o;
  logic        rsp_start_i = 1'b0;
  logic [3:0]  rsp_len_i = '0;
  logic [15:0] rsp_word_i = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cmd_responder #(.PULSE_CYC(PULSE)) u_cmd_responder (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .cmd_word_o(cmd_word_o),
    .cmd_valid_o(cmd_valid_o), .cmd_last_o(cmd_last_o), .rsp_start_i(rsp_start_i),
    .rsp_len_i(rsp_len_i), .rsp_word_i(rsp_word_i), .rsp_take_o(rsp_take_o)
  );

  // {first command word (extra-word count in [3:0]), response words minus one}
  localparam logic [19:0] VEC [4] = '{
    {16'hA5A0, 4'd0},
    {16'h3C02, 4'd1},
    {16'h7E01, 4'd2},
    {16'h0000, 4'd0}
  };

  logic [15:0] cap [8];
  logic        cap_last [8];
  int          ncap = 0;
  logic [15:0] rsp_mem [8];
  int          ridx = 0;

  function automatic logic [15:0] xw(logic [15:0] f, int k);
    return (k == 0) ? f : f ^ (16'(k) * 16'h1357);
  endfunction
  function automatic logic [15:0] rw(logic [15:0] f, int k);
    return (k == 0) ? (16'h8000 | ~f) : f + 16'(k) * 16'h0F0F;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) if (cmd_valid_o && ncap < 8) begin
    cap[ncap] = cmd_word_o; cap_last[ncap] = cmd_last_o; ncap++;
  end
  always @(negedge clk_i) if (rsp_take_o && ridx < 7) begin
    ridx++; rsp_word_i = rsp_mem[ridx];
  end

  task automatic send_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      sdata_i = w[i]; sclk_i = 1'b1; repeat (H) @(negedge clk_i);
      sclk_i = 1'b0; repeat (H) @(negedge clk_i);
    end
  endtask

  task automatic recv_word(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      sclk_i = 1'b1; repeat (H) @(negedge clk_i);
      w[i] = sdata_o; sclk_i = 1'b0; repeat (H) @(negedge clk_i);
    end
  endtask

  task automatic run_case(logic [15:0] first, logic [3:0] rlen, bit toggle_busy);
    int nw, lowc, n0;
    logic [15:0] got;
    nw = int'(first[3:0]) + 1;
    ncap = 0;
    for (int k = 0; k < nw; k++) send_word(xw(first, k));
    repeat (5) @(negedge clk_i);
    chk(ncap == nw, "R1 word count", ncap, nw);
    for (int k = 0; k < nw && k < 8; k++) begin
      chk(cap[k] == xw(first, k), "R1 command word", cap[k], xw(first, k));
      chk(cap_last[k] == (k == nw - 1), "R2 last flag", cap_last[k], k == nw - 1);
    end
    chk(sdata_oe_o && sdata_o, "R3 busy high", {sdata_oe_o, sdata_o}, 2'b11);
    if (toggle_busy) begin
      n0 = ncap;
      for (int i = 0; i < 16; i++) begin
        sdata_i = i[0]; sclk_i = 1'b1; repeat (H) @(negedge clk_i);
        sclk_i = 1'b0; repeat (H) @(negedge clk_i);
      end
      chk(ncap == n0, "R7 no strobe while busy", ncap, n0);
      chk(sdata_oe_o && sdata_o, "R7 busy kept", {sdata_oe_o, sdata_o}, 2'b11);
    end
    for (int k = 0; k < 8; k++) rsp_mem[k] = rw(first, k);
    ridx = 0; rsp_word_i = rsp_mem[0]; rsp_len_i = rlen;
    rsp_start_i = 1'b1;
    @(negedge clk_i); rsp_start_i = 1'b0;
    lowc = 0;
    while (sdata_oe_o && !sdata_o && !done) begin lowc++; @(negedge clk_i); end
    chk(lowc == PULSE, "R4 low pulse length", lowc, PULSE);
    for (int k = 0; k <= int'(rlen); k++) begin
      recv_word(got);
      chk(got == rw(first, k), "R5 response word", got, rw(first, k));
    end
    chk(ridx == int'(rlen) + 1, "R5 take count", ridx, int'(rlen) + 1);
    chk(!sdata_oe_o, "R6 line released", sdata_oe_o, 0);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!sdata_oe_o, "R9 reset line released", sdata_oe_o, 0);
    chk(!cmd_valid_o, "R9 reset no strobe", cmd_valid_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R8: start strobe while receiving is ignored
    rsp_start_i = 1'b1; @(negedge clk_i); rsp_start_i = 1'b0;
    repeat (PULSE + 5) @(negedge clk_i);
    chk(!sdata_oe_o, "R8 stray start ignored", sdata_oe_o, 0);
    chk(ncap == 0, "R8 no strobe", ncap, 0);

    foreach (VEC[i]) run_case(VEC[i][19:4], VEC[i][3:0], 1'b0);

    // R7: host clocking during busy; then a normal exchange still works
    run_case(16'h5A31, 4'd1, 1'b1);
    run_case(16'hFFF0, 4'd0, 1'b0);
    finish_run();
  end
endmodule